// File: doc/BRIEF.md
# Manchester Frame Transmitter

This block turns a frame of bytes into a Manchester-coded serial line. A frame opens with one preamble byte sent several times in a row. Payload bytes follow, drawn from an upstream data FIFO through a valid/ready handshake, until a set total byte count has gone out. Bit timing comes from a reference tick that fires once every `cfg_ref_div + 1` system clocks. Each data bit occupies `cfg_bit_ticks` ticks and is split into two halves of opposite level.

A one-cycle pulse on `tx_start` launches a frame. `busy` stays high for the whole frame and drops by itself once the last half-bit has been sent. At that point the sticky `done_flag` is set. If a payload byte is needed and the FIFO has none, the frame is abandoned: the sticky `under_flag` is set and the line falls back to its idle level.

The mode input chooses between two presets with fixed preamble and frame lengths, a user mode that takes the programmed values, and an off state. Further configuration inputs select:
- the encoding convention,
- the bit order,
- output inversion,
- the idle level.

Top module: `mtx_frame_tx`

## Requirements
- R1: After reset `busy`, `done_flag`, `under_flag` and `s_ready` are 0, and `line_out` is at the idle level given by R12.
- R2: The reference tick fires in the cycle where an internal counter, cleared by reset, equals `cfg_ref_div`. The counter then wraps to 0. Each bit spans `cfg_bit_ticks` ticks (at least 2). Its first half lasts `cfg_bit_ticks/2` ticks, rounded down, and its second half lasts the remaining ticks.
- R3: With `cfg_enc_sel`=1, a data 0 is sent high then low and a data 1 is sent low then high. With `cfg_enc_sel`=0, each half-bit takes the opposite level.
- R4: With `cfg_lsb_first`=1, bit 0 of each byte goes first; with 0, bit 7 goes first. With `cfg_tx_inv`=1, `line_out` is inverted at all times, including while idle.
- R5: In mode 3, a frame consists of `cfg_pre_num` copies of `cfg_pre_byte` (0 means 32) followed by payload bytes. The frame carries `cfg_frm_num` bytes in total (0 means 256). `s_ready` is high for exactly one cycle per payload byte, in the tick cycle where that byte is taken.
- R6: Mode 1 forces 5 preamble bytes and a 30-byte frame. Mode 2 forces the preamble byte 0x7E, 4 preamble bytes and a 64-byte frame.
- R7: In mode 0, `tx_start` is ignored and `busy` stays 0.
- R8: A start pulse while idle raises `busy` at the next edge and clears `done_flag`. The line stays idle until the next tick, where the first byte is taken. A start pulse while busy has no effect.
- R9: At the tick that ends the last bit of the final byte, `busy` falls, `done_flag` becomes 1 and the line returns to idle.
- R10: If `s_valid` is 0 when a payload byte is taken, `under_flag` is set, `busy` falls, `done_flag` stays 0 and the line returns to idle.
- R11: `done_flag` and `under_flag` hold until a cycle with `done_clr` or `under_clr` high, respectively. A set that falls in the same cycle as a clear wins.
- R12: Between frames the line carries bit 7 of `cfg_idle_pat`, so 0x00 gives a low idle and 0xFF gives a high idle, before any inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 0 off, 1 and 2 presets, 3 programmed lengths |
| cfg_enc_sel | input | 1 | Half-bit convention select |
| cfg_lsb_first | input | 1 | 1 sends bit 0 of each byte first |
| cfg_tx_inv | input | 1 | Inverts the line output |
| cfg_idle_pat | input | 8 | Idle pattern; bit 7 sets the idle level |
| cfg_pre_byte | input | 8 | Preamble byte for modes 1 and 3 |
| cfg_pre_num | input | 5 | Preamble repetitions in mode 3 (0 means 32) |
| cfg_frm_num | input | 8 | Frame byte total in mode 3 (0 means 256) |
| cfg_ref_div | input | 12 | Reference tick divider (tick period is value + 1 clocks) |
| cfg_bit_ticks | input | 8 | Reference ticks per bit |
| tx_start | input | 1 | Frame start pulse |
| done_clr | input | 1 | Clears the done flag |
| under_clr | input | 1 | Clears the underrun flag |
| s_data | input | 8 | Payload byte from the FIFO |
| s_valid | input | 1 | FIFO has a byte |
| s_ready | output | 1 | Payload byte taken this cycle |
| line_out | output | 1 | Manchester line signal |
| busy | output | 1 | Frame in progress |
| done_flag | output | 1 | Sticky frame-complete flag |
| under_flag | output | 1 | Sticky underrun flag |

## Verification
Two events can land on the same clock edge: a flag being set by the frame sequencer (completion or underrun) and a clear pulse arriving from outside. The bench provokes this by holding `under_clr` high through a frame that starves the FIFO, and `done_clr` high through a frame that completes. The bench expects each flag to read 1 for exactly the one cycle after its setting edge and 0 from the next edge on. The behavioural model predicts this on every clock, and explicit checks also read it directly.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_A    = 2'd1,
    MODE_B    = 2'd2,
    MODE_USER = 2'd3
  } mtx_mode_e;

  localparam int A_PRE_COUNT = 5;
  localparam int A_FRM_TOTAL = 30;
  localparam int B_PRE_COUNT = 4;
  localparam int B_FRM_TOTAL = 64;
  localparam logic [7:0] B_PATTERN = 8'h7E;
endpackage

// File: rtl/mtx_tick_gen.sv
module mtx_tick_gen #(
  parameter int DIVW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == div);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mtx_cfg_sel.sv
module mtx_cfg_sel
  import mtx_pkg::*;
#(
  parameter int DW   = 8,
  parameter int PREW = 5,
  parameter int FRMW = 8,
  localparam int CW  = FRMW + 1
) (
  input  logic [1:0]      mode,
  input  logic [DW-1:0]   pre_byte,
  input  logic [PREW-1:0] pre_num,
  input  logic [FRMW-1:0] frm_num,
  output logic            enabled,
  output logic [DW-1:0]   eff_byte,
  output logic [CW-1:0]   eff_pre,
  output logic [CW-1:0]   eff_total
);
  mtx_mode_e sel;

  always_comb begin
    sel       = mtx_mode_e'(mode);
    enabled   = (sel != MODE_OFF);
    eff_byte  = pre_byte;
    eff_pre   = (pre_num == '0) ? CW'(2 ** PREW) : CW'(pre_num);
    eff_total = (frm_num == '0) ? CW'(2 ** FRMW) : CW'(frm_num);
    case (sel)
      MODE_A: begin
        eff_pre   = CW'(A_PRE_COUNT);
        eff_total = CW'(A_FRM_TOTAL);
      end
      MODE_B: begin
        eff_byte  = DW'(B_PATTERN);
        eff_pre   = CW'(B_PRE_COUNT);
        eff_total = CW'(B_FRM_TOTAL);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mtx_bit_enc.sv
module mtx_bit_enc #(
  parameter int DW   = 8,
  localparam int BIW = $clog2(DW)
) (
  input  logic [DW-1:0]  byte_val,
  input  logic [BIW-1:0] bit_idx,
  input  logic           lsb_first,
  input  logic           first_half,
  input  logic           active,
  input  logic           enc_sel,
  input  logic           idle_lvl,
  input  logic           inv,
  output logic           line
);
  logic [DW-1:0] byte_rev;
  logic          data_bit;
  logic          lead_lvl;

  for (genvar i = 0; i < DW; i++) begin : g_rev
    assign byte_rev[i] = byte_val[DW-1-i];
  end

  always_comb begin
    data_bit = lsb_first ? byte_val[bit_idx] : byte_rev[bit_idx];
    lead_lvl = data_bit ^ enc_sel;
    if (active) line = (first_half ? lead_lvl : ~lead_lvl) ^ inv;
    else        line = idle_lvl ^ inv;
  end
endmodule

// File: rtl/mtx_frame_seq.sv
module mtx_frame_seq #(
  parameter int DW   = 8,
  parameter int BTW  = 8,
  parameter int CW   = 9,
  localparam int BIW = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           start,
  input  logic           enabled,
  input  logic [BTW-1:0] bit_ticks,
  input  logic [DW-1:0]  eff_byte,
  input  logic [CW-1:0]  eff_pre,
  input  logic [CW-1:0]  eff_total,
  input  logic [DW-1:0]  s_data,
  input  logic           s_valid,
  input  logic           done_clr,
  input  logic           under_clr,
  output logic           s_ready,
  output logic           busy,
  output logic           active,
  output logic [DW-1:0]  byte_val,
  output logic [BIW-1:0] bit_idx,
  output logic           first_half,
  output logic           done,
  output logic           under
);
  logic           busy_q, busy_d, arm_q, arm_d;
  logic [DW-1:0]  byte_q, byte_d;
  logic [BIW-1:0] bit_q, bit_d;
  logic [BTW-1:0] ph_q, ph_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           done_q, done_d, under_q, under_d;
  logic           step_en, bit_bnd, byte_bnd, frame_end, fetch, is_pay;
  logic           start_ok, underrun;

  always_comb begin
    start_ok  = !busy_q && start && enabled;
    step_en   = busy_q && tick;
    bit_bnd   = step_en && (arm_q || (ph_q == (bit_ticks - BTW'(1))));
    byte_bnd  = bit_bnd && (arm_q || (bit_q == BIW'(DW - 1)));
    frame_end = byte_bnd && (cnt_q == eff_total);
    fetch     = byte_bnd && !frame_end;
    is_pay    = (cnt_q >= eff_pre);
    s_ready   = fetch && is_pay;
    underrun  = s_ready && !s_valid;

    busy_d = busy_q;
    arm_d  = arm_q;
    byte_d = byte_q;
    bit_d  = bit_q;
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    if (start_ok) begin
      busy_d = 1'b1;
      arm_d  = 1'b1;
      cnt_d  = '0;
    end else if (step_en) begin
      if (frame_end || underrun) begin
        busy_d = 1'b0;
        arm_d  = 1'b0;
      end else if (fetch) begin
        byte_d = is_pay ? s_data : eff_byte;
        bit_d  = '0;
        ph_d   = '0;
        cnt_d  = cnt_q + 1'b1;
        arm_d  = 1'b0;
      end else if (bit_bnd) begin
        bit_d = bit_q + 1'b1;
        ph_d  = '0;
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end

    if (frame_end)                  done_d = 1'b1;
    else if (start_ok || done_clr)  done_d = 1'b0;
    else                            done_d = done_q;

    if (underrun)       under_d = 1'b1;
    else if (under_clr) under_d = 1'b0;
    else                under_d = under_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      arm_q  <= 1'b0;
      byte_q <= '0;
      bit_q  <= '0;
      ph_q   <= '0;
      cnt_q  <= '0;
    end else if (start_ok || step_en) begin
      busy_q <= busy_d;
      arm_q  <= arm_d;
      byte_q <= byte_d;
      bit_q  <= bit_d;
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      under_q <= 1'b0;
    end else begin
      done_q  <= done_d;
      under_q <= under_d;
    end
  end

  assign busy       = busy_q;
  assign active     = busy_q && !arm_q;
  assign byte_val   = byte_q;
  assign bit_idx    = bit_q;
  assign first_half = (ph_q < (bit_ticks >> 1));
  assign done       = done_q;
  assign under      = under_q;
endmodule

// File: rtl/mtx_frame_tx.sv
module mtx_frame_tx #(
  parameter int DW   = 8,
  parameter int PREW = 5,
  parameter int FRMW = 8,
  parameter int DIVW = 12,
  parameter int BTW  = 8,
  localparam int CW  = FRMW + 1,
  localparam int BIW = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_mode,
  input  logic            cfg_enc_sel,
  input  logic            cfg_lsb_first,
  input  logic            cfg_tx_inv,
  input  logic [DW-1:0]   cfg_idle_pat,
  input  logic [DW-1:0]   cfg_pre_byte,
  input  logic [PREW-1:0] cfg_pre_num,
  input  logic [FRMW-1:0] cfg_frm_num,
  input  logic [DIVW-1:0] cfg_ref_div,
  input  logic [BTW-1:0]  cfg_bit_ticks,
  input  logic            tx_start,
  input  logic            done_clr,
  input  logic            under_clr,
  input  logic [DW-1:0]   s_data,
  input  logic            s_valid,
  output logic            s_ready,
  output logic            line_out,
  output logic            busy,
  output logic            done_flag,
  output logic            under_flag
);
  logic           tick, enabled, active, first_half;
  logic [DW-1:0]  eff_byte, byte_val;
  logic [CW-1:0]  eff_pre, eff_total;
  logic [BIW-1:0] bit_idx;

  mtx_tick_gen #(.DIVW(DIVW)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(cfg_ref_div), .tick(tick)
  );

  mtx_cfg_sel #(.DW(DW), .PREW(PREW), .FRMW(FRMW)) u_cfg (
    .mode(cfg_mode), .pre_byte(cfg_pre_byte), .pre_num(cfg_pre_num),
    .frm_num(cfg_frm_num), .enabled(enabled), .eff_byte(eff_byte),
    .eff_pre(eff_pre), .eff_total(eff_total)
  );

  mtx_frame_seq #(.DW(DW), .BTW(BTW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(tx_start),
    .enabled(enabled), .bit_ticks(cfg_bit_ticks), .eff_byte(eff_byte),
    .eff_pre(eff_pre), .eff_total(eff_total), .s_data(s_data),
    .s_valid(s_valid), .done_clr(done_clr), .under_clr(under_clr),
    .s_ready(s_ready), .busy(busy), .active(active), .byte_val(byte_val),
    .bit_idx(bit_idx), .first_half(first_half), .done(done_flag),
    .under(under_flag)
  );

  mtx_bit_enc #(.DW(DW)) u_enc (
    .byte_val(byte_val), .bit_idx(bit_idx), .lsb_first(cfg_lsb_first),
    .first_half(first_half), .active(active), .enc_sel(cfg_enc_sel),
    .idle_lvl(cfg_idle_pat[DW-1]), .inv(cfg_tx_inv), .line(line_out)
  );
endmodule

// File: rtl/mtx_frame_tx_chk.sv
module mtx_frame_tx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cfg_mode,
  input logic          cfg_tx_inv,
  input logic [DW-1:0] cfg_idle_pat,
  input logic          tx_start,
  input logic          done_clr,
  input logic          s_valid,
  input logic          s_ready,
  input logic          line_out,
  input logic          busy,
  input logic          done_flag,
  input logic          under_flag
);
  AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> busy); // R5
  AST_MODE_OFF_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tx_start && cfg_mode == 2'd0) |=> !busy); // R7
  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done_flag); // R8
  AST_END_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done_flag || under_flag)); // R9
  AST_UNDERRUN_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_valid) |=> (!busy && under_flag)); // R10
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !done_clr && !tx_start) |=> done_flag); // R11
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (line_out == (cfg_idle_pat[DW-1] ^ cfg_tx_inv))); // R12
endmodule

bind mtx_frame_tx mtx_frame_tx_chk #(.DW(DW)) u_chk (.*);

// File: tb/mtx_frame_tx_bench.sv
module mtx_frame_tx_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_mode;
  logic       cfg_enc_sel, cfg_lsb_first, cfg_tx_inv;
  logic [7:0] cfg_idle_pat, cfg_pre_byte, cfg_frm_num, cfg_bit_ticks;
  logic [4:0] cfg_pre_num;
  logic [11:0] cfg_ref_div;
  logic       tx_start, done_clr, under_clr;
  logic [7:0] s_data;
  logic       s_valid;
  logic       s_ready, line_out, busy, done_flag, under_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  mtx_frame_tx u_mtx_frame_tx (.*);

  int    errs = 0;
  int    checks = 0;
  string cur_req = "R1";
  logic [7:0] q[$];

  bit         m_busy, m_arm, m_done, m_under;
  int         m_cnt, m_t;
  logic [7:0] m_byte;

  function automatic int eff_pre();
    if (cfg_mode == 2'd1) return 5;
    if (cfg_mode == 2'd2) return 4;
    return (cfg_pre_num == 0) ? 32 : int'(cfg_pre_num);
  endfunction

  function automatic int eff_total();
    if (cfg_mode == 2'd1) return 30;
    if (cfg_mode == 2'd2) return 64;
    return (cfg_frm_num == 0) ? 256 : int'(cfg_frm_num);
  endfunction

  function automatic logic [7:0] eff_pbyte();
    return (cfg_mode == 2'd2) ? 8'h7E : cfg_pre_byte;
  endfunction

  function automatic bit m_tick();
    return m_cnt == int'(cfg_ref_div);
  endfunction

  // index of the byte taken at this edge, or -1 when none
  function automatic int fetch_idx();
    int per;
    per = 8 * int'(cfg_bit_ticks);
    if (!m_busy || !m_tick()) return -1;
    if (m_arm) return 0;
    if (((m_t + 1) % per) == 0) return (m_t + 1) / per;
    return -1;
  endfunction

  function automatic bit exp_ready();
    int idx;
    idx = fetch_idx();
    return (idx >= 0) && (idx < eff_total()) && (idx >= eff_pre());
  endfunction

  function automatic bit exp_line();
    int n, ph, bi;
    bit b, lvl;
    n = int'(cfg_bit_ticks);
    if (m_busy && !m_arm) begin
      ph  = m_t % n;
      bi  = (m_t / n) % 8;
      b   = cfg_lsb_first ? m_byte[bi] : m_byte[7 - bi];
      lvl = (ph < n / 2) ? (b ^ cfg_enc_sel) : !(b ^ cfg_enc_sel);
    end else begin
      lvl = cfg_idle_pat[7];
    end
    return lvl ^ cfg_tx_inv;
  endfunction

  task automatic model_edge();
    int idx;
    bit tk, fin, und, st;
    idx = fetch_idx();
    tk  = m_tick();
    fin = 1'b0;
    und = 1'b0;
    st  = !m_busy && tx_start && (cfg_mode != 2'd0);
    if (st) begin
      m_busy = 1'b1;
      m_arm  = 1'b1;
    end else if (m_busy && tk) begin
      if (idx >= 0 && idx == eff_total()) begin
        fin = 1'b1;
        m_busy = 1'b0;
        m_arm  = 1'b0;
      end else if (idx >= 0) begin
        if (idx >= eff_pre()) begin
          if (q.size() == 0) und = 1'b1;
          else m_byte = q.pop_front();
        end else begin
          m_byte = eff_pbyte();
        end
        if (und) begin
          m_busy = 1'b0;
          m_arm  = 1'b0;
        end else begin
          if (m_arm) m_t = 0;
          else m_t++;
          m_arm = 1'b0;
        end
      end else begin
        m_t++;
      end
    end
    if (fin) m_done = 1'b1;
    else if (st || done_clr) m_done = 1'b0;
    if (und) m_under = 1'b1;
    else if (under_clr) m_under = 1'b0;
    m_cnt = tk ? 0 : m_cnt + 1;
  endtask

  task automatic chk(string req, string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, name, act, exp);
    end
  endtask

  task automatic compare();
    chk(cur_req, "busy", int'(busy), int'(m_busy));
    chk(cur_req, "done_flag", int'(done_flag), int'(m_done));
    chk(cur_req, "under_flag", int'(under_flag), int'(m_under));
    chk(cur_req, "s_ready", int'(s_ready), int'(exp_ready()));
    chk(cur_req, "line_out", int'(line_out), int'(exp_line()));
  endtask

  task automatic drive_fifo();
    s_valid = (q.size() > 0);
    s_data  = (q.size() > 0) ? q[0] : 8'h00;
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) model_edge();
    else begin
      m_busy = 0; m_arm = 0; m_done = 0; m_under = 0; m_cnt = 0; m_t = 0;
      m_byte = 0;
    end
    @(negedge clk);
    if (rst_n) compare();
    drive_fifo();
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic push(logic [7:0] b);
    q.push_back(b);
    drive_fifo();
  endtask

  task automatic start_frame();
    tx_start = 1'b1;
    step();
    tx_start = 1'b0;
  endtask

  task automatic run_idle(int limit);
    int n;
    n = 0;
    while (busy && n < limit) begin
      step();
      n++;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    cfg_mode = 2'd3; cfg_enc_sel = 1'b1; cfg_lsb_first = 1'b0; cfg_tx_inv = 1'b0;
    cfg_idle_pat = 8'h00; cfg_pre_byte = 8'hA5; cfg_pre_num = 5'd2;
    cfg_frm_num = 8'd4; cfg_ref_div = 12'd3; cfg_bit_ticks = 8'd4;
    tx_start = 1'b0; done_clr = 1'b0; under_clr = 1'b0;
    s_data = 8'h00; s_valid = 1'b0;
    steps(3);
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done_flag", int'(done_flag), 0);
    chk("R1", "under_flag", int'(under_flag), 0);
    chk("R1", "s_ready", int'(s_ready), 0);
    chk("R1", "line_out", int'(line_out), 0);

    // R7 mode 0 ignores start
    cur_req = "R7";
    cfg_mode = 2'd0;
    start_frame();
    steps(3);
    chk("R7", "busy", int'(busy), 0);

    // R3 encoding, MSB first, start and ignored restart (R8)
    cur_req = "R3";
    cfg_mode = 2'd3;
    push(8'h3C); push(8'h81);
    start_frame();
    chk("R8", "busy after start", int'(busy), 1);
    chk("R8", "done after start", int'(done_flag), 0);
    steps(40);
    cur_req = "R8";
    start_frame();
    cur_req = "R3";
    run_idle(3000);
    chk("R9", "done at end", int'(done_flag), 1);
    chk("R9", "busy at end", int'(busy), 0);
    chk("R5", "fifo drained", q.size(), 0);

    // R4 LSB first, inverted line; R12 idle high
    cur_req = "R4";
    cfg_enc_sel = 1'b0; cfg_lsb_first = 1'b1; cfg_tx_inv = 1'b1;
    cfg_idle_pat = 8'hFF;
    step();
    chk("R12", "idle high inverted", int'(line_out), 0);
    push(8'h96); push(8'h01);
    start_frame();
    run_idle(3000);
    chk("R4", "done", int'(done_flag), 1);

    // R2 odd bit length, slower tick
    cur_req = "R2";
    cfg_ref_div = 12'd4; cfg_bit_ticks = 8'd5; cfg_tx_inv = 1'b0;
    cfg_idle_pat = 8'h00; cfg_pre_num = 5'd1; cfg_frm_num = 8'd3;
    push(8'h5A); push(8'hF0);
    start_frame();
    run_idle(4000);
    chk("R2", "done", int'(done_flag), 1);
    chk("R12", "idle low", int'(line_out), 0);

    // R10 underrun
    cur_req = "R10";
    cfg_bit_ticks = 8'd2;
    push(8'hC7);
    start_frame();
    run_idle(2000);
    chk("R10", "under set", int'(under_flag), 1);
    chk("R10", "done not set", int'(done_flag), 0);
    chk("R10", "busy cleared", int'(busy), 0);
    cur_req = "R11";
    steps(10);
    chk("R11", "under sticky", int'(under_flag), 1);
    under_clr = 1'b1; step(); under_clr = 1'b0;
    chk("R11", "under cleared", int'(under_flag), 0);

    // R11 set and clear in the same cycle
    push(8'h11);
    under_clr = 1'b1;
    start_frame();
    run_idle(2000);
    chk("R11", "under set wins", int'(under_flag), 1);
    step();
    chk("R11", "under cleared next", int'(under_flag), 0);
    under_clr = 1'b0;
    push(8'h22); push(8'h33);
    done_clr = 1'b1;
    start_frame();
    run_idle(2000);
    chk("R11", "done set wins", int'(done_flag), 1);
    step();
    chk("R11", "done cleared next", int'(done_flag), 0);
    done_clr = 1'b0;

    // R6 presets
    cur_req = "R6";
    cfg_mode = 2'd1; cfg_pre_byte = 8'hC3;
    for (int i = 0; i < 25; i++) push(8'(i * 7 + 1));
    start_frame();
    run_idle(6000);
    chk("R6", "mode 1 done", int'(done_flag), 1);
    chk("R6", "mode 1 payload", q.size(), 0);
    chk("R6", "mode 1 no underrun", int'(under_flag), 0);
    cfg_mode = 2'd2;
    for (int i = 0; i < 60; i++) push(8'(i * 13 + 5));
    start_frame();
    run_idle(9000);
    chk("R6", "mode 2 done", int'(done_flag), 1);
    chk("R6", "mode 2 payload", q.size(), 0);
    chk("R6", "mode 2 no underrun", int'(under_flag), 0);

    // R5 zero counts mean 32 and 256
    cur_req = "R5";
    cfg_mode = 2'd3; cfg_pre_num = 5'd0; cfg_frm_num = 8'd0;
    for (int i = 0; i < 224; i++) push(8'(i * 29 + 3));
    start_frame();
    run_idle(25000);
    chk("R5", "long frame done", int'(done_flag), 1);
    chk("R5", "long frame payload", q.size(), 0);
    chk("R5", "long frame no underrun", int'(under_flag), 0);

    summary();
    $finish;
  end
endmodule